// File: doc/BRIEF.md
# BCD Digital-Ramp Conversion Controller

This block sequences a continuously running digital-ramp analog-to-digital conversion meant for a decimal voltmeter readout. It keeps a chain of decimal digit counters, each holding a value from 0 to 9 in four bits. The packed count goes straight to an external converter whose analog output climbs one step per clock. An external analog comparator sets a single input high while the converter output is at or below the measured voltage. It pulls that input low once the converter output rises above the measured voltage.

The comparator input is resynchronised through a chain of flip-flops. When a high-to-low transition is seen, the count that produced it is captured into the display digit registers and the counters return to zero. A fresh ramp then starts with no external command. If the count reaches all nines and the comparator still has not tripped, the block captures all nines and raises an over-range flag. Each captured digit is also decoded into a seven-segment pattern. The display registers change only at a capture, so a partial count is never shown.

Top module: `bcdr_ramp_adc`

## Requirements
- R1: While reset is asserted and directly after its release, `dac_code` is zero, `digits` is zero, `over_range` is 0, and every segment group shows the pattern for 0.
- R2: `dac_code` advances by exactly one decimal count per clock. Digit 0 sits in bits [3:0] and digit i in bits [4i+3:4i]. Each digit stays within 0..9, and a carry passes to the next digit when a digit wraps from 9 to 0. At all nines the count holds and does not wrap.
- R3: The captured result is the smallest code whose converter level lies above the input, that is, the first code for which `cmp_in` is low. The result therefore rounds up. For example, with one code per volt, an input of 11.2 V gives 12.
- R4: `cmp_in` passes through SYNC_STAGES flip-flops. A code that makes `cmp_in` low is captured at the clock edge SYNC_STAGES+1 cycles after that code first appears on `dac_code`. The time between restarts is therefore the result plus SYNC_STAGES+1 cycles.
- R5: At the same edge as each capture, `dac_code` returns to zero and a new ramp begins, so conversions repeat without any start command.
- R6: `digits` changes only at a capture edge. Throughout a ramp it keeps the value from the previous capture.
- R7: If the count reaches all nines and the synchronised comparator still reports high for that code, the capture loads all nines into `digits` and sets `over_range` to 1. The next in-range capture clears `over_range` to 0.
- R8: Each group `seg[7i+6:7i]` is the active-high seven-segment pattern of digit i, with segment a in bit 0 through segment g in bit 6. The patterns for 0..9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Comparator: high while the converter level is at or below the input, low once it is above |
| dac_code | output | 4*NDIG | Packed BCD ramp count driving the external converter |
| digits | output | 4*NDIG | Latched BCD result of the last conversion |
| seg | output | 7*NDIG | Active-high seven-segment patterns, one group per digit |
| over_range | output | 1 | Last conversion ran past all nines without a comparator trip |

## Verification
A broken carry or a digit leaving the 0..9 range shows up on `dac_code` within a single clock. A misaligned latency pipeline shows up as results that are off by one or more codes, and as restart spacing that does not match the result plus the synchroniser depth. Stale synchroniser state left over after a restart would produce a spurious extra capture or over-range within a few cycles of the new ramp. Sweeping the input across the full decimal range, including the last code and one step past it, exposes each of these at the first conversion after the input settles.

// File: rtl/bcdr_pkg.sv
package bcdr_pkg;
   localparam int unsigned DIGIT_W = 4;
   localparam int unsigned SEG_W   = 7;

   typedef logic [DIGIT_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0]   seg_t;

   localparam bcd_t BCD_TOP = 4'd9;

   // segment a in bit 0 .. segment g in bit 6, active high
   function automatic seg_t bcd_to_seg(input bcd_t d);
      seg_t s;
      case (d)
         4'd0: s = 7'h3F;
         4'd1: s = 7'h06;
         4'd2: s = 7'h5B;
         4'd3: s = 7'h4F;
         4'd4: s = 7'h66;
         4'd5: s = 7'h6D;
         4'd6: s = 7'h7D;
         4'd7: s = 7'h07;
         4'd8: s = 7'h7F;
         4'd9: s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/bcdr_sync.sv
module bcdr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/bcdr_decade_chain.sv
module bcdr_decade_chain
   import bcdr_pkg::*;
#(
   parameter int unsigned NDIG = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   output logic [NDIG*DIGIT_W-1:0] count
);
   logic [NDIG:0] carry;
   logic [NDIG:0] nines_so_far;
   bcd_t          dig [NDIG];

   // the chain holds at all nines instead of wrapping the top digit
   assign nines_so_far[0] = 1'b1;
   assign carry[0]        = ~nines_so_far[NDIG];

   for (genvar g = 0; g < NDIG; g++) begin : g_digit
      assign nines_so_far[g+1] = nines_so_far[g] & (dig[g] == BCD_TOP);
      assign carry[g+1]        = carry[g] & (dig[g] == BCD_TOP);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          dig[g] <= '0;
         else if (clear)      dig[g] <= '0;
         else if (carry[g])   dig[g] <= (dig[g] == BCD_TOP) ? '0 : dig[g] + 4'd1;
      end

      assign count[g*DIGIT_W +: DIGIT_W] = dig[g];
   end
endmodule

// File: rtl/bcdr_seg_bank.sv
module bcdr_seg_bank
   import bcdr_pkg::*;
#(
   parameter int unsigned NDIG = 3
) (
   input  logic [NDIG*DIGIT_W-1:0] digits,
   output logic [NDIG*SEG_W-1:0]   seg
);
   for (genvar g = 0; g < NDIG; g++) begin : g_dec
      assign seg[g*SEG_W +: SEG_W] = bcd_to_seg(digits[g*DIGIT_W +: DIGIT_W]);
   end
endmodule

// File: rtl/bcdr_ramp_adc.sv
module bcdr_ramp_adc
   import bcdr_pkg::*;
#(
   parameter int unsigned NDIG        = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmp_in,
   output logic [NDIG*DIGIT_W-1:0] dac_code,
   output logic [NDIG*DIGIT_W-1:0] digits,
   output logic [NDIG*SEG_W-1:0]   seg,
   output logic                    over_range
);
   localparam int unsigned CODE_W   = NDIG*DIGIT_W;
   localparam int unsigned SETTLE_W = $clog2(SYNC_STAGES+1);
   localparam logic [CODE_W-1:0]   ALL_NINES  = {NDIG{BCD_TOP}};
   localparam logic [SETTLE_W-1:0] SETTLE_LD  = SETTLE_W'(SYNC_STAGES);

   if (NDIG < 1 || NDIG > 6) begin : g_bad_ndig
      $error("bcdr_ramp_adc: NDIG must lie in 1..6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bcdr_ramp_adc: SYNC_STAGES must be at least 2");
   end

   logic [CODE_W-1:0]   cnt;
   logic                cmp_s;
   logic                cmp_prev;
   logic [CODE_W-1:0]   code_pipe [SYNC_STAGES];
   logic [SETTLE_W-1:0] settle;
   logic                armed;
   logic                trip;
   logic                overflow;
   logic                restart;

   bcdr_decade_chain #(.NDIG(NDIG)) i_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart),
      .count (cnt)
   );

   bcdr_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_in),
      .q     (cmp_s)
   );

   // code history aligned with the synchroniser latency
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) code_pipe[g] <= '0;
         else if (g == 0) code_pipe[g] <= cnt;
         else code_pipe[g] <= code_pipe[(g == 0) ? 0 : g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_prev <= 1'b0;
      else        cmp_prev <= cmp_s;
   end

   // ignore stale synchroniser and pipeline contents just after a restart
   assign armed    = (settle == '0);
   assign trip     = armed & cmp_prev & ~cmp_s;
   assign overflow = armed & cmp_s & (code_pipe[SYNC_STAGES-1] == ALL_NINES);
   assign restart  = trip | overflow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        settle <= SETTLE_LD;
      else if (restart)  settle <= SETTLE_LD;
      else if (!armed)   settle <= settle - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         digits     <= '0;
         over_range <= 1'b0;
      end else if (trip) begin
         digits     <= code_pipe[SYNC_STAGES-1];
         over_range <= 1'b0;
      end else if (overflow) begin
         digits     <= ALL_NINES;
         over_range <= 1'b1;
      end
   end

   assign dac_code = cnt;

   bcdr_seg_bank #(.NDIG(NDIG)) i_seg (
      .digits (digits),
      .seg    (seg)
   );
endmodule

// File: rtl/bcdr_ramp_adc_chk.sv
module bcdr_ramp_adc_chk
   import bcdr_pkg::*;
#(
   parameter int unsigned NDIG = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NDIG*DIGIT_W-1:0] dac_code,
   input logic [NDIG*DIGIT_W-1:0] digits,
   input logic [NDIG*SEG_W-1:0]   seg,
   input logic                    over_range
);
   localparam logic [NDIG*DIGIT_W-1:0] NINES   = {NDIG{BCD_TOP}};
   localparam logic [NDIG*SEG_W-1:0]   NINE_SG = {NDIG{7'h6F}};

   function automatic bit all_bcd(input logic [NDIG*DIGIT_W-1:0] c);
      bit ok = 1'b1;
      for (int i = 0; i < NDIG; i++)
         if (c[i*DIGIT_W +: DIGIT_W] > BCD_TOP) ok = 1'b0;
      return ok;
   endfunction

   function automatic int to_int(input logic [NDIG*DIGIT_W-1:0] c);
      int v = 0;
      for (int i = NDIG-1; i >= 0; i--)
         v = v*10 + int'(c[i*DIGIT_W +: DIGIT_W]);
      return v;
   endfunction

   p_bcd_digits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      all_bcd(dac_code));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_code != NINES) |=>
         (dac_code == '0) || (to_int(dac_code) == to_int($past(dac_code)) + 1));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(digits) |-> (dac_code == '0));

   p_nines_r7: assert property (@(posedge clk) disable iff (!rst_n)
      over_range |-> (digits == NINES));

   p_seg_nines_r8: assert property (@(posedge clk) disable iff (!rst_n)
      over_range |-> (seg == NINE_SG));
endmodule

bind bcdr_ramp_adc bcdr_ramp_adc_chk #(.NDIG(NDIG)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dac_code   (dac_code),
   .digits     (digits),
   .seg        (seg),
   .over_range (over_range)
);

// File: tb/test_bcdr_ramp_adc.sv
module test_bcdr_ramp_adc;
   localparam int CLK_PERIOD = 10;
   localparam int NDIG       = 2;
   localparam int SYNC       = 2;
   localparam int MAXV       = 99;

   localparam logic [6:0] SEGTAB [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                          7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   int          vin = 0;   // input voltage in tenths of a code step
   logic        cmp_in;
   logic [7:0]  dac_code;
   logic [7:0]  digits;
   logic [13:0] seg;
   logic        over_range;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int dec(input logic [7:0] c);
      return int'(c[7:4])*10 + int'(c[3:0]);
   endfunction

   // model of the external converter and comparator
   assign cmp_in = (dec(dac_code)*10 <= vin);

   bcdr_ramp_adc #(.NDIG(NDIG), .SYNC_STAGES(SYNC)) i_bcdr_ramp_adc (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_in     (cmp_in),
      .dac_code   (dac_code),
      .digits     (digits),
      .seg        (seg),
      .over_range (over_range)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_restart(output int cycles, output bit hold_ok,
                               output bit step_ok, output bit timed_out);
      logic [7:0] prev;
      logic [7:0] held;
      prev = dac_code;
      held = digits;
      cycles = 0; hold_ok = 1'b1; step_ok = 1'b1; timed_out = 1'b0;
      forever begin
         @(negedge clk);
         cycles++;
         if (dac_code == 8'h00 && prev != 8'h00) break;
         if (digits !== held) hold_ok = 1'b0;
         if (dac_code[3:0] > 4'd9 || dac_code[7:4] > 4'd9) step_ok = 1'b0;
         if (!(dec(dac_code) == dec(prev) + 1 ||
               (dec(prev) == MAXV && dec(dac_code) == MAXV))) step_ok = 1'b0;
         prev = dac_code;
         if (cycles > 500) begin timed_out = 1'b1; break; end
      end
   endtask

   task automatic run_case(input int v);
      int  cyc, t, exp_d, exp_p;
      bit  h, s, to, exp_o;
      @(negedge clk);
      vin = v;
      wait_restart(cyc, h, s, to);          // flush the ramp seen with the old input
      wait_restart(cyc, h, s, to);
      t = v/10 + 1;
      exp_o = (t > MAXV);
      exp_d = exp_o ? MAXV : t;
      exp_p = exp_d + SYNC + 1;
      check(!to, "R5", "ramp restarted", int'(to), 0);
      check(s, "R2", "ramp steps", int'(s), 1);
      check(h, "R6", "display held during ramp", int'(h), 1);
      check(cyc == exp_p, "R4", "restart spacing", cyc, exp_p);
      if (exp_o) check(dec(digits) == exp_d, "R7", "over-range digits", dec(digits), exp_d);
      else       check(dec(digits) == exp_d, "R3", "rounded-up result", dec(digits), exp_d);
      check(over_range == exp_o, "R7", "over_range flag", int'(over_range), int'(exp_o));
      check(seg == {SEGTAB[exp_d/10], SEGTAB[exp_d%10]}, "R8", "segment pattern",
            int'(seg), int'({SEGTAB[exp_d/10], SEGTAB[exp_d%10]}));
   endtask

   initial begin
      #(CLK_PERIOD*190000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      check(dac_code == 8'h00, "R1", "dac_code in reset", int'(dac_code), 0);
      check(digits == 8'h00 && over_range == 1'b0, "R1", "digits in reset", int'(digits), 0);
      check(seg == {7'h3F, 7'h3F}, "R1", "segments in reset", int'(seg), int'({7'h3F, 7'h3F}));
      rst_n = 1'b1;
      @(negedge clk);
      check(dac_code == 8'h01, "R1", "first step after release", int'(dac_code), 1);
      check(digits == 8'h00 && over_range == 1'b0, "R1", "digits after release", int'(digits), 0);

      for (int i = 0; i <= 80; i++) run_case(i*13);
      run_case(0);
      run_case(112);    // 11.2 steps rounds up to 12
      run_case(110);    // exact 11 still rounds up to 12
      run_case(985);    // trips on the last code
      run_case(990);    // one step beyond: over-range
      run_case(45);     // in-range after over-range clears the flag
      run_case(9);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule